// File: doc/BRIEF.md
# Burst Subchannel Byte/Doubleword Buffer

This block is the data path of a single burst-mode subchannel. On one side sits a device that moves one byte per transfer. On the other side sits a shared control engine that moves whole 64-bit doublewords. Two doubleword registers sit between them and take turns. A lane counter picks the byte position the device side touches next. A separate remaining-byte counter ends the transfer on the exact byte count, even when that count falls in the middle of a doubleword.

In a read, device bytes are packed into the active register. When the register is full, or when the last byte of the count arrives, the register is handed to the engine with a primary request and a byte-valid mask. The device then continues into the other register. In a write, the block first prefetches up to two doublewords with secondary requests. It then offers their bytes to the device one lane at a time. Each time a register empties and more data is still owed, it asks for a refill with a primary request.

Top module: `burst_dw_buffer`

## Requirements
- R1: After reset the block is idle: `busy`, `pri_req`, `sec_req`, `dev_avail` and `overrun` are all 0.
- R2: In a read, the k-th device byte of a doubleword (k = 0 first) is placed at bits 8k+7:8k of `eng_wdata`. A register that receives 8 bytes raises `pri_req` with `eng_mask` = 8'hFF.
- R3: In a read whose count is not a multiple of 8, the final register is handed over after exactly the remaining bytes. Its `eng_mask` has the low k bits set, where k is the number of bytes in that register. `busy` falls once every register has been acknowledged.
- R4: The device side moves on to the other register while the first one awaits `eng_ack`. The engine receives the doublewords in the order they were filled.
- R5: A write of N bytes raises `sec_req` for the first min(2, ceil(N/8)) doublewords and `pri_req` for each further doubleword. A request appears only when the register in turn is empty. No request appears once ceil(N/8) doublewords have been acknowledged.
- R6: In a write, `dev_avail` is high while the current register holds unsent bytes. `dev_byte_out` presents lanes 0 to 7 in order. After exactly N accepted `dev_take` pulses the transfer ends.
- R7: A device byte that arrives while both registers await service sets `overrun`. That byte is dropped and not counted. `overrun` stays set until the next accepted start.
- R8: A start with a zero count is ignored. A start while `busy` is high is ignored and leaves the running transfer unchanged.
- R9: `pri_req` and `sec_req` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted when idle and count nonzero) |
| dir_write | input | 1 | 1 = write (engine to device), 0 = read |
| count_i | input | CNT_W | Total byte count of the transfer |
| dev_valid | input | 1 | Read: device presents `dev_byte_in` |
| dev_byte_in | input | 8 | Read data byte from device |
| dev_take | input | 1 | Write: device takes `dev_byte_out` |
| dev_byte_out | output | 8 | Write data byte for device |
| dev_avail | output | 1 | Write: a byte is available |
| pri_req | output | 1 | Primary request to the engine |
| sec_req | output | 1 | Secondary (prefetch) request to the engine |
| eng_ack | input | 1 | Engine services the raised request this cycle |
| eng_rdata | input | 8*DW_BYTES | Write: doubleword delivered with `eng_ack` |
| eng_wdata | output | 8*DW_BYTES | Read: doubleword offered with `pri_req` |
| eng_mask | output | DW_BYTES | Read: valid-byte mask of `eng_wdata` |
| busy | output | 1 | Transfer active or data awaiting service |
| overrun | output | 1 | Sticky: device byte lost for lack of space |

## Verification
Several properties are checked on every cycle: the two request lines never overlap, no request or byte offer appears while idle, the read mask is always a contiguous run from lane 0, the remaining-byte counter never reaches zero while a transfer is active, and an overrun flag never clears on its own. Other behaviours can only be shown by the bench scenarios. These are the byte-to-lane packing, the exact placement of a mid-doubleword end, the sequence of secondary and then primary requests for a write, the dropping of the byte lost in an overrun, and the rejection of a start that arrives mid-transfer.

// File: rtl/bb_pkg.sv
package bb_pkg;
    typedef enum logic {
        XFER_READ  = 1'b0,
        XFER_WRITE = 1'b1
    } xfer_dir_e;

    localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/bb_lane_mask.sv
module bb_lane_mask #(
    parameter int unsigned DW_BYTES = 8,
    localparam int unsigned LANE_W = $clog2(DW_BYTES)
) (
    input  logic [LANE_W-1:0]   last_lane_i,
    output logic [DW_BYTES-1:0] mask_o
);
    for (genvar g = 0; g < DW_BYTES; g++) begin : g_bit
        assign mask_o[g] = (LANE_W'(g) <= last_lane_i);
    end
endmodule

// File: rtl/bb_byte_pick.sv
module bb_byte_pick #(
    parameter int unsigned DW_BYTES = 8,
    localparam int unsigned LANE_W = $clog2(DW_BYTES),
    localparam int unsigned WORD_W = DW_BYTES * bb_pkg::BYTE_W
) (
    input  logic [WORD_W-1:0]         word_i,
    input  logic [LANE_W-1:0]         lane_i,
    output logic [bb_pkg::BYTE_W-1:0] byte_o
);
    logic [DW_BYTES-1:0][bb_pkg::BYTE_W-1:0] lanes;

    for (genvar g = 0; g < DW_BYTES; g++) begin : g_lane
        assign lanes[g] = word_i[g*bb_pkg::BYTE_W +: bb_pkg::BYTE_W];
    end

    assign byte_o = lanes[lane_i];
endmodule

// File: rtl/burst_dw_buffer.sv
module burst_dw_buffer #(
    parameter int unsigned DW_BYTES = 8,
    parameter int unsigned CNT_W    = 16,
    localparam int unsigned LANE_W = $clog2(DW_BYTES),
    localparam int unsigned WORD_W = DW_BYTES * bb_pkg::BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 dir_write,
    input  logic [CNT_W-1:0]     count_i,
    input  logic                 dev_valid,
    input  logic [7:0]           dev_byte_in,
    input  logic                 dev_take,
    output logic [7:0]           dev_byte_out,
    output logic                 dev_avail,
    output logic                 pri_req,
    output logic                 sec_req,
    input  logic                 eng_ack,
    input  logic [WORD_W-1:0]    eng_rdata,
    output logic [WORD_W-1:0]    eng_wdata,
    output logic [DW_BYTES-1:0]  eng_mask,
    output logic                 busy,
    output logic                 overrun
);
    import bb_pkg::*;

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(DW_BYTES - 1);

    typedef struct packed {
        logic [1:0][WORD_W-1:0]   word;
        logic [1:0][DW_BYTES-1:0] mask;
        logic [1:0]               full;
        logic                     dev_sel;
        logic                     eng_sel;
        logic [LANE_W-1:0]        lane;
        logic [CNT_W-1:0]         end_cnt;
        logic [CNT_W-1:0]         fetch_left;
        logic [1:0]               pf;
        logic                     active;
        xfer_dir_e                dir;
        logic                     ovr;
    } state_t;

    state_t q, d;

    logic [DW_BYTES-1:0] close_mask;
    logic [CNT_W:0]      words_needed;
    logic                closing;
    logic                take_ok;
    logic                fill_ok;
    logic                start_ok;

    bb_lane_mask #(.DW_BYTES(DW_BYTES)) mask_i (
        .last_lane_i (q.lane),
        .mask_o      (close_mask)
    );

    bb_byte_pick #(.DW_BYTES(DW_BYTES)) pick_i (
        .word_i (q.word[q.dev_sel]),
        .lane_i (q.lane),
        .byte_o (dev_byte_out)
    );

    assign busy      = q.active | (|q.full);
    assign overrun   = q.ovr;
    assign dev_avail = q.active && (q.dir == XFER_WRITE) && q.full[q.dev_sel];
    assign eng_wdata = q.word[q.eng_sel];
    assign eng_mask  = q.mask[q.eng_sel];

    always_comb begin
        pri_req = 1'b0;
        sec_req = 1'b0;
        if (q.dir == XFER_READ) begin
            pri_req = q.full[q.eng_sel];
        end else if (q.active && q.fetch_left != '0 && !q.full[q.eng_sel]) begin
            if (q.pf == 2'd2) pri_req = 1'b1;
            else              sec_req = 1'b1;
        end
    end

    assign words_needed = ({1'b0, count_i} + (CNT_W+1)'(DW_BYTES - 1)) >> LANE_W;
    assign closing      = (q.lane == LAST_LANE) || (q.end_cnt == CNT_W'(1));
    assign start_ok     = start && !busy && (count_i != '0);
    assign fill_ok      = q.active && (q.dir == XFER_READ) && dev_valid && !q.full[q.dev_sel];
    assign take_ok      = dev_avail && dev_take;

    always_comb begin
        d = q;
        if (start_ok) begin
            d.active     = 1'b1;
            d.dir        = dir_write ? XFER_WRITE : XFER_READ;
            d.end_cnt    = count_i;
            d.fetch_left = CNT_W'(words_needed);
            d.pf         = 2'd0;
            d.lane       = '0;
            d.dev_sel    = 1'b0;
            d.eng_sel    = 1'b0;
            d.full       = '0;
            d.ovr        = 1'b0;
        end else begin
            // engine side: service of the register in turn
            if (eng_ack && (pri_req || sec_req)) begin
                if (q.dir == XFER_WRITE) begin
                    d.word[q.eng_sel] = eng_rdata;
                    d.full[q.eng_sel] = 1'b1;
                    d.fetch_left      = q.fetch_left - CNT_W'(1);
                    if (q.pf != 2'd2) d.pf = q.pf + 2'd1;
                end else begin
                    d.full[q.eng_sel] = 1'b0;
                end
                d.eng_sel = ~q.eng_sel;
            end
            // device side: lost byte on read
            if (q.active && (q.dir == XFER_READ) && dev_valid && q.full[q.dev_sel]) begin
                d.ovr = 1'b1;
            end
            if (fill_ok) begin
                d.word[q.dev_sel][{q.lane, 3'b000} +: 8] = dev_byte_in;
            end
            if (fill_ok || take_ok) begin
                d.end_cnt = q.end_cnt - CNT_W'(1);
                d.lane    = q.lane + LANE_W'(1);
                if (q.end_cnt == CNT_W'(1)) d.active = 1'b0;
                if (closing) begin
                    d.full[q.dev_sel] = fill_ok;
                    if (fill_ok) d.mask[q.dev_sel] = close_mask;
                    d.dev_sel = ~q.dev_sel;
                    d.lane    = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R9: request lines are exclusive
    a_r9_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pri_req, sec_req}));

    // R9: nothing offered while idle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pri_req && !sec_req && !dev_avail));

    // R3: read mask is a contiguous run starting at lane 0
    a_r3_mask_contig: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_req && q.dir == XFER_READ) |->
            (eng_mask[0] && ((eng_mask & (eng_mask + DW_BYTES'(1))) == '0)));

    // R6: remaining count never exhausted while a transfer runs
    a_r6_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        q.active |-> (q.end_cnt != '0));

    // R7: overrun is sticky until an accepted start
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !(start && !busy)) |=> overrun);
endmodule

// File: tb/burst_dw_buffer_tb_top.sv
module burst_dw_buffer_tb_top;
    localparam int DWB = 8;
    localparam int CW  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_write = 1'b0;
    logic [CW-1:0] count_i = '0;
    logic        dev_valid = 1'b0;
    logic [7:0]  dev_byte_in = '0;
    logic        dev_take = 1'b0;
    logic [7:0]  dev_byte_out;
    logic        dev_avail;
    logic        pri_req, sec_req;
    logic        eng_ack = 1'b0;
    logic [63:0] eng_rdata = '0;
    logic [63:0] eng_wdata;
    logic [7:0]  eng_mask;
    logic        busy, overrun;

    int total = 0;
    int bad = 0;
    int n_pri = 0;
    int n_sec = 0;
    bit ack_en = 1'b0;
    bit rd_mode = 1'b1;
    bit done_flag = 1'b0;

    logic [71:0] exp_words[$];
    logic [63:0] src_words[$];
    logic [7:0]  exp_bytes[$];

    always #2.5 clk = ~clk;

    burst_dw_buffer #(.DW_BYTES(DWB), .CNT_W(CW)) dut_i (
        .clk, .rst_n, .start, .dir_write, .count_i,
        .dev_valid, .dev_byte_in, .dev_take, .dev_byte_out, .dev_avail,
        .pri_req, .sec_req, .eng_ack, .eng_rdata, .eng_wdata, .eng_mask,
        .busy, .overrun
    );

    task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bv(input int i, input int seed);
        return 8'(i * 37 + seed);
    endfunction

    // scoreboard pushers
    task automatic push_read(input int n, input int seed);
        logic [63:0] w = '0;
        logic [7:0]  m = '0;
        for (int i = 0; i < n; i++) begin
            w[(i%8)*8 +: 8] = bv(i, seed);
            m[i%8] = 1'b1;
            if (i % 8 == 7 || i == n - 1) begin
                exp_words.push_back({m, w});
                w = '0;
                m = '0;
            end
        end
    endtask

    task automatic push_write(input int n, input int seed);
        logic [63:0] w = '0;
        for (int i = 0; i < n; i++) begin
            w[(i%8)*8 +: 8] = bv(i, seed);
            exp_bytes.push_back(bv(i, seed));
            if (i % 8 == 7 || i == n - 1) begin
                src_words.push_back(w);
                w = '0;
            end
        end
    endtask

    // engine model and monitor
    always @(negedge clk) begin
        eng_ack = 1'b0;
        if (rst_n && ack_en && (pri_req || sec_req)) begin
            if (sec_req) n_sec++;
            if (pri_req) n_pri++;
            if (rd_mode) begin
                if (exp_words.size() == 0) begin
                    chk(1'b0, "R2 unexpected word", {eng_mask, eng_wdata}, 72'h0);
                end else begin
                    logic [71:0] e;
                    logic [63:0] bm;
                    e = exp_words.pop_front();
                    for (int l = 0; l < 8; l++) bm[l*8 +: 8] = {8{e[64+l]}};
                    chk((eng_mask == e[71:64]) && ((eng_wdata & bm) == e[63:0]),
                        "R2 R3 R4 read word", {eng_mask, eng_wdata & bm}, e);
                end
            end else begin
                if (src_words.size() != 0) eng_rdata = src_words.pop_front();
            end
            eng_ack = 1'b1;
        end
    end

    task automatic do_start(input bit wr, input int n);
        @(negedge clk);
        start = 1'b1;
        dir_write = wr;
        count_i = CW'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_bytes(input int from, input int to, input int seed);
        for (int i = from; i < to; i++) begin
            @(negedge clk);
            dev_valid = 1'b1;
            dev_byte_in = bv(i, seed);
        end
        @(negedge clk);
        dev_valid = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int guard = 0;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(!busy, tag, {71'h0, busy}, 72'h0);
    endtask

    task automatic take_bytes(input int n);
        int got = 0;
        int guard = 0;
        while (got < n && guard < 4000) begin
            @(negedge clk);
            dev_take = 1'b0;
            if (dev_avail) begin
                logic [7:0] e;
                e = exp_bytes.pop_front();
                chk(dev_byte_out == e, "R6 write byte", {64'h0, dev_byte_out}, {64'h0, e});
                dev_take = 1'b1;
                got++;
            end
            guard++;
        end
        @(negedge clk);
        dev_take = 1'b0;
        chk(got == n, "R6 byte count", 72'(got), 72'(n));
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({busy, pri_req, sec_req, dev_avail, overrun} == 5'b0, "R1 reset state",
            {67'h0, busy, pri_req, sec_req, dev_avail, overrun}, 72'h0);

        // R2: read of two full doublewords
        rd_mode = 1'b1; ack_en = 1'b1;
        push_read(16, 3);
        do_start(1'b0, 16);
        send_bytes(0, 16, 3);
        wait_idle("R2 idle after read");
        chk(exp_words.size() == 0, "R2 all words seen", 72'(exp_words.size()), 72'h0);

        // R3: read ending mid-doubleword (20 bytes -> mask 0F)
        push_read(20, 11);
        do_start(1'b0, 20);
        send_bytes(0, 20, 11);
        wait_idle("R3 idle after partial");
        chk(exp_words.size() == 0, "R3 partial word seen", 72'(exp_words.size()), 72'h0);

        // R8: zero count ignored
        do_start(1'b0, 0);
        chk(!busy, "R8 zero count", {71'h0, busy}, 72'h0);

        // R4 R7: overrun with engine stalled
        ack_en = 1'b0;
        push_read(24, 5);
        do_start(1'b0, 24);
        send_bytes(0, 16, 5);
        chk(pri_req && !overrun, "R4 both held no overrun", {70'h0, pri_req, overrun}, 72'h2);
        // R8: start while busy ignored
        do_start(1'b1, 5);
        chk(pri_req && !dev_avail && !sec_req, "R8 busy start ignored",
            {69'h0, pri_req, dev_avail, sec_req}, 72'h4);
        @(negedge clk);
        dev_valid = 1'b1; dev_byte_in = 8'hEE;
        @(negedge clk);
        dev_valid = 1'b0;
        chk(overrun, "R7 overrun set", {71'h0, overrun}, 72'h1);
        ack_en = 1'b1;
        repeat (4) @(negedge clk);
        send_bytes(16, 24, 5);
        wait_idle("R7 idle after overrun");
        chk(exp_words.size() == 0, "R7 dropped byte not counted", 72'(exp_words.size()), 72'h0);
        chk(overrun, "R7 overrun sticky", {71'h0, overrun}, 72'h1);

        // R5 R6: write of 20 bytes (3 doublewords)
        rd_mode = 1'b0; n_pri = 0; n_sec = 0;
        push_write(20, 9);
        do_start(1'b1, 20);
        chk(!overrun, "R7 cleared by start", {71'h0, overrun}, 72'h0);
        take_bytes(20);
        wait_idle("R6 idle after write");
        chk(n_sec == 2 && n_pri == 1, "R5 request mix 20", 72'(n_sec * 16 + n_pri), 72'h21);

        // R5 R6: short write, single fetch
        n_pri = 0; n_sec = 0;
        push_write(5, 21);
        do_start(1'b1, 5);
        take_bytes(5);
        wait_idle("R6 idle after short write");
        chk(n_sec == 1 && n_pri == 0, "R5 request mix 5", 72'(n_sec * 16 + n_pri), 72'h10);
        chk(!sec_req && !pri_req, "R9 quiet after write", {70'h0, pri_req, sec_req}, 72'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule